// File: doc/BRIEF.md
# Condition-Code Arithmetic Unit for an 8-bit Accumulator Processor

This block is the arithmetic and logic datapath of a small accumulator processor. Each cycle it may be handed an operation code, an 8-bit operand pair (or a 16-bit word pair for the wide subtract) and the processor's present condition-code byte. From these it computes a result and a new condition-code byte. Both are captured into output registers on the clock edge at which `valid_i` is high. The surrounding core feeds the registered condition codes back into `cc_i` on later operations.

Each operation follows its own flag rules. Flags that an operation does not define are copied from `cc_i` unchanged. Eight-bit results appear in the low byte of `res_o` with the high byte cleared. Multiply and the wide subtract fill all 16 bits. The test operation updates only the flags and leaves `res_o` as it was.

Condition-code layout, bit 7 down to bit 0: E, F, H, I, N, Z, V, C.

Top module: `alu_cc_unit`

## Requirements
- R1: An active-low asynchronous reset clears `res_o` to 0x0000 and `cc_o` to 0x00.
- R2: While `valid_i` is low, `res_o` and `cc_o` hold their values. With `valid_i` high and an op code of 0xB to 0xF, they also hold.
- R3: Increment (op 0x0) returns `a_i`+1 modulo 256. N and Z follow the result. V is set only when `a_i` is 0x7F. H is set only when the low nibble of `a_i` is 0xF. C is copied from `cc_i`.
- R4: Logical shift right (op 0x1) moves `a_i` right by one with 0 entering bit 7. The new C is old bit 0, N is 0 and Z follows the result. V is copied from `cc_i`.
- R5: Rotate left (op 0x2) moves `a_i` left by one with the incoming C entering bit 0. The new C is old bit 7 and V is old bit 7 XOR old bit 6. N and Z follow the result.
- R6: Rotate right (op 0x3) moves `a_i` right by one with the incoming C entering bit 7. The new C is old bit 0 and N and Z follow the result. V is copied from `cc_i`.
- R7: Negate (op 0x4) returns 0 minus `a_i` modulo 256. V is set exactly when `a_i` is 0x80. C is set exactly when `a_i` is nonzero. N and Z follow the result.
- R8: Subtract (op 0x5) returns `a_i`-`b_i`. Subtract with borrow (op 0x6) returns `a_i`-`b_i`-C. In both, N and Z follow the result and C is the borrow out of bit 7. V is set when the operand signs differ and the result sign differs from `a_i`.
- R9: Wide subtract (op 0x7) returns `wa_i`-`wb_i` as 16 bits. The flags use the same rules as R8 at 16 bits, with N taken from bit 15.
- R10: Sign extend (op 0x8) returns 0x00FF when bit 7 of `a_i` is set and 0x0000 otherwise. N and Z are taken from `a_i`. V and C are copied from `cc_i`.
- R11: Test (op 0x9) sets N and Z from `a_i` and clears V and C. `res_o` keeps its previous value.
- R12: Multiply (op 0xA) returns the unsigned 16-bit product of `a_i` and `b_i`. Z is set when the whole product is zero and C equals bit 7 of the product. N and V are copied from `cc_i`.
- R13: For every op code from 0x0 to 0xA, E, F and I (bits 7, 6, 4) are copied from `cc_i`. H (bit 5) is copied for every op except increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture strobe for the current operation |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First 8-bit operand |
| b_i | input | 8 | Second 8-bit operand |
| wa_i | input | 16 | Minuend of the wide subtract |
| wb_i | input | 16 | Subtrahend of the wide subtract |
| cc_i | input | 8 | Present condition-code byte |
| res_o | output | 16 | Registered result |
| cc_o | output | 8 | Registered condition codes |

## Verification
The hardest cases to reach from the ports are the ones whose outcome depends on state left behind by an earlier operation. Test must leave the result register untouched, so the bench runs it straight after a multiply whose result is known. An undefined op code must leave both registers untouched, so it is placed after a test that left a distinctive flag pattern. Borrow-in for subtract with borrow is reached only by presenting C=1 in `cc_i`. The bench pairs that borrow with operands that bring the difference exactly to zero, and with operands that bring it exactly to a wrap to 0xFF. The single overflowing negate input, 0x80, is driven directly, next to the zero and one cases.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

    typedef enum logic [3:0] {
        OP_INC  = 4'h0,
        OP_LSR  = 4'h1,
        OP_ROL  = 4'h2,
        OP_ROR  = 4'h3,
        OP_NEG  = 4'h4,
        OP_SUB  = 4'h5,
        OP_SBC  = 4'h6,
        OP_SUBW = 4'h7,
        OP_SEX  = 4'h8,
        OP_TST  = 4'h9,
        OP_MUL  = 4'hA
    } alu_op_e;

    localparam int CC_E = 7;
    localparam int CC_F = 6;
    localparam int CC_H = 5;
    localparam int CC_I = 4;
    localparam int CC_N = 3;
    localparam int CC_Z = 2;
    localparam int CC_V = 1;
    localparam int CC_C = 0;
    localparam int CC_W = 8;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/alu_subtract.sv
module alu_subtract #(
    parameter int W = 8
) (
    input  logic [W-1:0]        minuend_i,
    input  logic [W-1:0]        subtrahend_i,
    input  logic                borrow_i,
    output logic [W-1:0]        diff_o,
    output alu_cc_pkg::nzvc_t   flags_o
);
    logic [W:0] wide_d;

    always_comb begin
        wide_d  = {1'b0, minuend_i} - {1'b0, subtrahend_i} - {{W{1'b0}}, borrow_i};
        diff_o  = wide_d[W-1:0];
        flags_o.n = wide_d[W-1];
        flags_o.z = ~|wide_d[W-1:0];
        flags_o.v = (minuend_i[W-1] ^ subtrahend_i[W-1]) & (minuend_i[W-1] ^ wide_d[W-1]);
        flags_o.c = wide_d[W];
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
    parameter int W = 8
) (
    input  logic [3:0]          op_i,
    input  logic [W-1:0]        a_i,
    input  logic                carry_i,
    output logic [W-1:0]        res_o,
    output logic                half_o,
    output alu_cc_pkg::nzvc_t   flags_o
);
    import alu_cc_pkg::*;

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        res_o     = a_i;
        half_o    = 1'b0;
        flags_o.v = 1'b0;
        flags_o.c = carry_i;
        case (op_i)
            OP_INC: begin
                res_o     = a_i + {{(W-1){1'b0}}, 1'b1};
                flags_o.v = (a_i == MAX_POS);
                half_o    = &a_i[3:0];
            end
            OP_LSR: begin
                res_o     = {1'b0, a_i[W-1:1]};
                flags_o.c = a_i[0];
            end
            OP_ROL: begin
                res_o     = {a_i[W-2:0], carry_i};
                flags_o.c = a_i[W-1];
                flags_o.v = a_i[W-1] ^ a_i[W-2];
            end
            OP_ROR: begin
                res_o     = {carry_i, a_i[W-1:1]};
                flags_o.c = a_i[0];
            end
            OP_SEX: begin
                res_o     = {W{a_i[W-1]}};
            end
            default: begin
                res_o     = a_i;
            end
        endcase
        flags_o.n = res_o[W-1];
        flags_o.z = ~|res_o;
    end
endmodule

// File: rtl/alu_multiply.sv
module alu_multiply #(
    parameter int W = 8
) (
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [2*W-1:0]  prod_o
);
    localparam int P = 2 * W;

    for (genvar k = 0; k < W; k++) begin : g_row
        logic [P-1:0] part;
        logic [P-1:0] sum;
        assign part = b_i[k] ? (P'(a_i) << k) : '0;
        if (k == 0) begin : g_first
            assign sum = part;
        end else begin : g_rest
            assign sum = g_row[k-1].sum + part;
        end
    end

    assign prod_o = g_row[W-1].sum;
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic [3:0]           op_i,
    input  logic [DATA_W-1:0]    a_i,
    input  logic [DATA_W-1:0]    b_i,
    input  logic [2*DATA_W-1:0]  wa_i,
    input  logic [2*DATA_W-1:0]  wb_i,
    input  logic [7:0]           cc_i,
    output logic [2*DATA_W-1:0]  res_o,
    output logic [7:0]           cc_o
);
    import alu_cc_pkg::*;

    localparam int WIDE_W = 2 * DATA_W;
    localparam logic [DATA_W-1:0] SIGN_ONLY = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [3:0] LAST_OP = 4'(OP_MUL);

    typedef struct packed {
        logic [WIDE_W-1:0] res;
        logic [CC_W-1:0]   cc;
    } unit_state_t;

    unit_state_t state_d, state_q;

    // Narrow subtractor shared by subtract, subtract-with-borrow, negate and test
    logic [DATA_W-1:0] sub_m, sub_s, sub_diff;
    logic              sub_bin;
    nzvc_t             sub_fl;

    always_comb begin
        sub_m   = (op_i == OP_NEG) ? '0 : a_i;
        sub_s   = (op_i == OP_NEG) ? a_i : ((op_i == OP_TST) ? '0 : b_i);
        sub_bin = (op_i == OP_SBC) & cc_i[CC_C];
    end

    alu_subtract #(.W(DATA_W)) u_sub_narrow (
        .minuend_i    (sub_m),
        .subtrahend_i (sub_s),
        .borrow_i     (sub_bin),
        .diff_o       (sub_diff),
        .flags_o      (sub_fl)
    );

    logic [WIDE_W-1:0] subw_diff;
    nzvc_t             subw_fl;

    alu_subtract #(.W(WIDE_W)) u_sub_wide (
        .minuend_i    (wa_i),
        .subtrahend_i (wb_i),
        .borrow_i     (1'b0),
        .diff_o       (subw_diff),
        .flags_o      (subw_fl)
    );

    logic [DATA_W-1:0] bit_res;
    logic              bit_half;
    nzvc_t             bit_fl;

    alu_bitops #(.W(DATA_W)) u_bitops (
        .op_i    (op_i),
        .a_i     (a_i),
        .carry_i (cc_i[CC_C]),
        .res_o   (bit_res),
        .half_o  (bit_half),
        .flags_o (bit_fl)
    );

    logic [WIDE_W-1:0] mul_prod;

    alu_multiply #(.W(DATA_W)) u_mul (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (mul_prod)
    );

    logic [CC_W-1:0] cc_n;

    always_comb begin
        state_d = state_q;
        cc_n    = cc_i;
        if (valid_i) begin
            case (op_i)
                OP_INC: begin
                    state_d.res = {{DATA_W{1'b0}}, bit_res};
                    cc_n[CC_H]  = bit_half;
                    cc_n[CC_N]  = bit_fl.n;
                    cc_n[CC_Z]  = bit_fl.z;
                    cc_n[CC_V]  = bit_fl.v;
                    state_d.cc  = cc_n;
                end
                OP_LSR, OP_ROR: begin
                    state_d.res = {{DATA_W{1'b0}}, bit_res};
                    cc_n[CC_N]  = bit_fl.n;
                    cc_n[CC_Z]  = bit_fl.z;
                    cc_n[CC_C]  = bit_fl.c;
                    state_d.cc  = cc_n;
                end
                OP_ROL: begin
                    state_d.res = {{DATA_W{1'b0}}, bit_res};
                    cc_n[CC_N]  = bit_fl.n;
                    cc_n[CC_Z]  = bit_fl.z;
                    cc_n[CC_V]  = bit_fl.v;
                    cc_n[CC_C]  = bit_fl.c;
                    state_d.cc  = cc_n;
                end
                OP_NEG, OP_SUB, OP_SBC: begin
                    state_d.res = {{DATA_W{1'b0}}, sub_diff};
                    cc_n[CC_N]  = sub_fl.n;
                    cc_n[CC_Z]  = sub_fl.z;
                    cc_n[CC_V]  = sub_fl.v;
                    cc_n[CC_C]  = sub_fl.c;
                    state_d.cc  = cc_n;
                end
                OP_TST: begin
                    cc_n[CC_N]  = sub_fl.n;
                    cc_n[CC_Z]  = sub_fl.z;
                    cc_n[CC_V]  = sub_fl.v;
                    cc_n[CC_C]  = sub_fl.c;
                    state_d.cc  = cc_n;
                end
                OP_SUBW: begin
                    state_d.res = subw_diff;
                    cc_n[CC_N]  = subw_fl.n;
                    cc_n[CC_Z]  = subw_fl.z;
                    cc_n[CC_V]  = subw_fl.v;
                    cc_n[CC_C]  = subw_fl.c;
                    state_d.cc  = cc_n;
                end
                OP_SEX: begin
                    state_d.res = {{DATA_W{1'b0}}, bit_res};
                    cc_n[CC_N]  = a_i[DATA_W-1];
                    cc_n[CC_Z]  = ~|a_i;
                    state_d.cc  = cc_n;
                end
                OP_MUL: begin
                    state_d.res = mul_prod;
                    cc_n[CC_Z]  = ~|mul_prod;
                    cc_n[CC_C]  = mul_prod[7];
                    state_d.cc  = cc_n;
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign res_o = state_q.res;
    assign cc_o  = state_q.cc;

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(res_o) && $stable(cc_o)));

    // R7
    neg_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_NEG) |=> (cc_o[CC_V] == ($past(a_i) == SIGN_ONLY)));

    // R5
    rol_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_ROL) |=> (cc_o[CC_V] == ($past(a_i[DATA_W-1]) ^ $past(a_i[DATA_W-2]))));

    // R11
    tst_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_TST) |=> ($stable(res_o) && !cc_o[CC_V] && !cc_o[CC_C]));

    // R12
    mul_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == OP_MUL) |=> (cc_o[CC_Z] == (res_o == '0)));

    // R13
    mask_bits_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i <= LAST_OP) |=>
            (cc_o[CC_E] == $past(cc_i[CC_E]) && cc_o[CC_F] == $past(cc_i[CC_F])
             && cc_o[CC_I] == $past(cc_i[CC_I])));

    // R2
    undefined_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i > LAST_OP) |=> ($stable(res_o) && $stable(cc_o)));
endmodule

// File: tb/alu_cc_unit_test.sv
module alu_cc_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [7:0]  a_i = '0;
    logic [7:0]  b_i = '0;
    logic [15:0] wa_i = '0;
    logic [15:0] wb_i = '0;
    logic [7:0]  cc_i = '0;
    logic [15:0] res_o;
    logic [7:0]  cc_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    alu_cc_unit uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .wa_i(wa_i), .wb_i(wb_i), .cc_i(cc_i),
        .res_o(res_o), .cc_o(cc_o)
    );

    // {req, op, wa (a in low byte), wb (b in low byte), cc_in, expected res, expected cc}
    localparam int NV = 26;
    localparam logic [71:0] VEC [NV] = '{
        {4'd3,  4'h0, 16'h007F, 16'h0000, 8'h00, 16'h0080, 8'h2A}, // R3 overflow, half
        {4'd3,  4'h0, 16'h00FF, 16'h0000, 8'h01, 16'h0000, 8'h25}, // R3 wrap, C kept
        {4'd13, 4'h0, 16'h0012, 16'h0000, 8'hD0, 16'h0013, 8'hD0}, // R13 E F I kept
        {4'd4,  4'h1, 16'h0081, 16'h0000, 8'h02, 16'h0040, 8'h03}, // R4 V kept
        {4'd4,  4'h1, 16'h0001, 16'h0000, 8'h08, 16'h0000, 8'h05}, // R4 zero
        {4'd5,  4'h2, 16'h0040, 16'h0000, 8'h01, 16'h0081, 8'h0A}, // R5 carry in
        {4'd5,  4'h2, 16'h0080, 16'h0000, 8'h00, 16'h0000, 8'h07}, // R5 carry out
        {4'd6,  4'h3, 16'h0001, 16'h0000, 8'h02, 16'h0000, 8'h07}, // R6 V kept
        {4'd6,  4'h3, 16'h0002, 16'h0000, 8'h01, 16'h0081, 8'h08}, // R6 carry in
        {4'd7,  4'h4, 16'h0080, 16'h0000, 8'h00, 16'h0080, 8'h0B}, // R7 only overflow
        {4'd7,  4'h4, 16'h0000, 16'h0000, 8'h0F, 16'h0000, 8'h04}, // R7 zero
        {4'd7,  4'h4, 16'h0001, 16'h0000, 8'h20, 16'h00FF, 8'h29}, // R7 one, H kept
        {4'd8,  4'h5, 16'h0050, 16'h00B0, 8'h01, 16'h00A0, 8'h0B}, // R8 C ignored
        {4'd8,  4'h6, 16'h0010, 16'h0010, 8'h01, 16'h00FF, 8'h09}, // R8 borrow wraps
        {4'd8,  4'h6, 16'h0010, 16'h000F, 8'h01, 16'h0000, 8'h04}, // R8 borrow zero
        {4'd9,  4'h7, 16'h8000, 16'h0001, 8'h00, 16'h7FFF, 8'h02}, // R9 overflow
        {4'd9,  4'h7, 16'h1234, 16'h1234, 8'h09, 16'h0000, 8'h04}, // R9 zero
        {4'd9,  4'h7, 16'h0000, 16'h0001, 8'h00, 16'hFFFF, 8'h09}, // R9 borrow
        {4'd10, 4'h8, 16'h0080, 16'h0000, 8'h03, 16'h00FF, 8'h0B}, // R10 negative
        {4'd10, 4'h8, 16'h0000, 16'h0000, 8'h00, 16'h0000, 8'h04}, // R10 zero
        {4'd12, 4'hA, 16'h00FF, 16'h00FF, 8'h0A, 16'hFE01, 8'h0A}, // R12 max
        {4'd12, 4'hA, 16'h0010, 16'h0008, 8'h00, 16'h0080, 8'h01}, // R12 carry bit 7
        {4'd12, 4'hA, 16'h0000, 16'h0037, 8'h01, 16'h0000, 8'h04}, // R12 zero
        {4'd11, 4'h9, 16'h0080, 16'h0000, 8'h03, 16'h0000, 8'h08}, // R11 result kept
        {4'd11, 4'h9, 16'h0000, 16'h0000, 8'hF0, 16'h0000, 8'hF4}, // R11 zero
        {4'd2,  4'hF, 16'h00AA, 16'h0055, 8'h00, 16'h0000, 8'hF4}  // R2 undefined op
    };

    task automatic check(input string tag, input logic [15:0] r_exp, input logic [7:0] c_exp);
        checks++;
        if (res_o !== r_exp || cc_o !== c_exp) begin
            errors++;
            $display("FAIL %s: res=%h cc=%h expected res=%h cc=%h", tag, res_o, cc_o, r_exp, c_exp);
        end
    endtask

    task automatic apply(input logic [3:0] op, input logic [15:0] wa, input logic [15:0] wb,
                         input logic [7:0] cc);
        @(negedge clk);
        valid_i = 1'b1;
        op_i    = op;
        wa_i    = wa;
        wb_i    = wb;
        a_i     = wa[7:0];
        b_i     = wb[7:0];
        cc_i    = cc;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", 16'h0000, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][67:64], VEC[i][63:48], VEC[i][47:32], VEC[i][31:24]);
            check($sformatf("R%0d vector %0d", VEC[i][71:68], i), VEC[i][23:8], VEC[i][7:0]);
        end

        // R3 half carry from a nibble of ones below a clear upper nibble
        apply(4'h0, 16'h000F, 16'h0000, 8'h00);
        check("R3 half", 16'h0010, 8'h20);

        // R2 strobe low: inputs that would change both registers are ignored
        @(negedge clk);
        valid_i = 1'b0;
        op_i = 4'h4; a_i = 8'h80; cc_i = 8'hFF;
        repeat (2) @(posedge clk);
        #2;
        check("R2 strobe low", 16'h0010, 8'h20);

        // R1 reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        check("R1 async reset", 16'h0000, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        apply(4'hA, 16'h0002, 16'h0003, 8'h00);
        check("R12 after reset", 16'h0006, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule